// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical timing for a parallel RGB panel. Two 12-bit counters step through each line and each frame. Every count runs from the start of its sync pulse, which is count 0. The horizontal counter advances once per pixel-clock cycle. The vertical counter advances once per line.

Software programs four values for each axis:
- sync end: the count at which the sync pulse ends, so it equals the sync width;
- display start: the first active count, placed after the back porch;
- display end: the first count past the active region;
- total: the full period of the line or frame.

From these values the block drives the following outputs:
- horizontal sync, vertical sync and data-enable, each with its own polarity;
- pixel coordinates relative to the top-left corner of the active area;
- a one-cycle end-of-frame pulse.

Software starts the raster with a start request and stops it with a stop request. A stop request lets the current frame finish. Once the raster has stopped, a stopped flag rises. An end-of-frame status bit is set every frame. Software clears it with a one-cycle clear pulse, and an enable input gates it onto an interrupt line. The timing values are captured only at the start of a frame. A write in the middle of a frame therefore never tears the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, the horizontal count goes 0..h_total-1 and then wraps to 0. The vertical count advances when the horizontal count wraps, and it wraps to 0 after v_total-1. A frame lasts h_total*v_total cycles. eof_pulse is high only in the cycle whose counts are (h_total-1, v_total-1).
- R2: Horizontal sync is active while the horizontal count is below h_sync_end. Vertical sync is active on every line whose vertical count is below v_sync_end.
- R3: Data-enable is active when h_disp_start <= h < h_disp_end and v_disp_start <= v < v_disp_end. During that window px_x = h - h_disp_start and px_y = v - v_disp_start. Outside it, both coordinates are 0.
- R4: When a polarity input (hs_pol_low, vs_pol_low, de_pol_low) is 1, its output is active low; when it is 0, the output is active high. While the raster is stopped, each of these outputs sits at its inactive level.
- R5: After reset the raster is stopped, sts_disabled is 1, sts_eof is 0 and irq is 0.
- R6: A start request (en_req high for one cycle) while stopped makes the next cycle count (0,0) and clears sts_disabled and sts_eof.
- R7: A stop request (dis_req) while running has no effect until the end-of-frame cycle. sts_disabled rises in the cycle after that end-of-frame cycle, and the outputs go idle at the same time. A stop request while stopped is ignored.
- R8: A start request made while a stop is pending cancels the stop without restarting the counters. A start request while running is ignored.
- R9: sts_eof is set in the cycle after each eof_pulse. A clear pulse (eof_clr) resets it, but a set in the same cycle wins. irq equals sts_eof AND eof_irq_en.
- R10: All eight timing values are captured at the start request and at each frame boundary. A change in the middle of a frame first takes effect in the next frame.
- R11: A stop request in the end-of-frame cycle itself stops the raster at that frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Start request pulse |
| dis_req | input | 1 | Stop request pulse |
| h_sync_end | input | 12 | Horizontal count where the sync pulse ends |
| h_disp_start | input | 12 | First active horizontal count |
| h_disp_end | input | 12 | First horizontal count past the active region |
| h_total | input | 12 | Counts per line |
| v_sync_end | input | 12 | Line where the vertical sync ends |
| v_disp_start | input | 12 | First active line |
| v_disp_end | input | 12 | First line past the active region |
| v_total | input | 12 | Lines per frame |
| hs_pol_low | input | 1 | Horizontal sync active low |
| vs_pol_low | input | 1 | Vertical sync active low |
| de_pol_low | input | 1 | Data-enable active low |
| eof_irq_en | input | 1 | Gates sts_eof onto irq |
| eof_clr | input | 1 | Clears sts_eof |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| px_x | output | 12 | Active-area column |
| px_y | output | 12 | Active-area row |
| eof_pulse | output | 1 | High in the last cycle of a frame |
| sts_disabled | output | 1 | Raster has stopped |
| sts_eof | output | 1 | End-of-frame status |
| irq | output | 1 | End-of-frame interrupt |

## Verification
A wrong horizontal count shows on hsync and de within one line. A wrong vertical count shows within one frame, as data-enable or the end-of-frame pulse landing at the wrong cycle offset from the start request. A control state stuck in drain, or a lost stop, shows on sts_disabled one cycle after the frame end where it should have risen. Captured timing values that load too early show as an end-of-frame pulse at the new period inside the frame that was running when they were written.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int unsigned NUM_AXES = 2;
    localparam int unsigned AX_H     = 0;
    localparam int unsigned AX_V     = 1;

    typedef enum logic [1:0] {
        CTL_OFF   = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_DRAIN = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/rtg_axis.sv
module rtg_axis #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         adv,
    input  logic         reload,
    input  logic [W-1:0] cfg_sync_end,
    input  logic [W-1:0] cfg_disp_start,
    input  logic [W-1:0] cfg_disp_end,
    input  logic [W-1:0] cfg_total,
    output logic         last,
    output logic         in_sync,
    output logic         in_disp,
    output logic [W-1:0] pos
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] sync_end;
        logic [W-1:0] disp_start;
        logic [W-1:0] disp_end;
        logic [W-1:0] total;
    } axis_st_t;

    axis_st_t st_d, st_q;
    logic [W-1:0] wrap_at;

    // Last count of the period; a zero total degenerates to a period of one.
    assign wrap_at = (st_q.total == '0) ? '0 : st_q.total - W'(1);
    assign last    = (st_q.cnt >= wrap_at);

    always_comb begin
        st_d = st_q;
        if (start || reload) begin
            st_d.sync_end   = cfg_sync_end;
            st_d.disp_start = cfg_disp_start;
            st_d.disp_end   = cfg_disp_end;
            st_d.total      = cfg_total;
        end
        if (start) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = last ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_sync = (st_q.cnt < st_q.sync_end);
    assign in_disp = (st_q.cnt >= st_q.disp_start) && (st_q.cnt < st_q.disp_end);
    assign pos     = in_disp ? (st_q.cnt - st_q.disp_start) : '0;

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
    import rtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic at_wrap,
    input  logic eof_irq_en,
    input  logic eof_clr,
    output logic running,
    output logic start,
    output logic frame_end,
    output logic sts_disabled,
    output logic sts_eof,
    output logic irq
);

    typedef struct packed {
        ctl_state_e st;
        logic       stopped;
        logic       eof;
    } ctl_st_t;

    ctl_st_t c_d, c_q;

    assign running   = (c_q.st != CTL_OFF);
    assign start     = (c_q.st == CTL_OFF) && en_req;
    assign frame_end = running && at_wrap;

    always_comb begin
        c_d = c_q;
        if (eof_clr) begin
            c_d.eof = 1'b0;
        end
        if (frame_end) begin
            c_d.eof = 1'b1;
        end
        case (c_q.st)
            CTL_OFF: begin
                if (en_req) begin
                    c_d.st      = CTL_RUN;
                    c_d.stopped = 1'b0;
                    c_d.eof     = 1'b0;
                end
            end
            CTL_RUN: begin
                if (dis_req) begin
                    if (frame_end) begin
                        c_d.st      = CTL_OFF;
                        c_d.stopped = 1'b1;
                    end else begin
                        c_d.st = CTL_DRAIN;
                    end
                end
            end
            CTL_DRAIN: begin
                if (en_req) begin
                    c_d.st = CTL_RUN;
                end else if (frame_end) begin
                    c_d.st      = CTL_OFF;
                    c_d.stopped = 1'b1;
                end
            end
            default: begin
                c_d.st = CTL_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st      <= CTL_OFF;
            c_q.stopped <= 1'b1;
            c_q.eof     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sts_disabled = c_q.stopped;
    assign sts_eof      = c_q.eof;
    assign irq          = c_q.eof && eof_irq_en;

endmodule

// File: rtl/rtg_out.sv
module rtg_out #(
    parameter int unsigned W = 12
) (
    input  logic         running,
    input  logic         h_sync,
    input  logic         v_sync,
    input  logic         h_disp,
    input  logic         v_disp,
    input  logic [W-1:0] h_pos,
    input  logic [W-1:0] v_pos,
    input  logic         hs_pol_low,
    input  logic         vs_pol_low,
    input  logic         de_pol_low,
    output logic         hsync,
    output logic         vsync,
    output logic         de,
    output logic [W-1:0] px_x,
    output logic [W-1:0] px_y
);

    logic active;

    assign active = running && h_disp && v_disp;
    assign hsync  = (running && h_sync) ^ hs_pol_low;
    assign vsync  = (running && v_sync) ^ vs_pol_low;
    assign de     = active ^ de_pol_low;
    assign px_x   = active ? h_pos : '0;
    assign px_y   = active ? v_pos : '0;

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic [CNT_W-1:0] h_sync_end,
    input  logic [CNT_W-1:0] h_disp_start,
    input  logic [CNT_W-1:0] h_disp_end,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_sync_end,
    input  logic [CNT_W-1:0] v_disp_start,
    input  logic [CNT_W-1:0] v_disp_end,
    input  logic [CNT_W-1:0] v_total,
    input  logic             hs_pol_low,
    input  logic             vs_pol_low,
    input  logic             de_pol_low,
    input  logic             eof_irq_en,
    input  logic             eof_clr,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] px_x,
    output logic [CNT_W-1:0] px_y,
    output logic             eof_pulse,
    output logic             sts_disabled,
    output logic             sts_eof,
    output logic             irq
);

    logic                running;
    logic                start;
    logic                frame_end;
    logic [NUM_AXES-1:0] adv;
    logic [NUM_AXES-1:0] last;
    logic [NUM_AXES-1:0] in_sync;
    logic [NUM_AXES-1:0] in_disp;
    logic [CNT_W-1:0]    pos        [NUM_AXES];
    logic [CNT_W-1:0]    cfg_se     [NUM_AXES];
    logic [CNT_W-1:0]    cfg_ds     [NUM_AXES];
    logic [CNT_W-1:0]    cfg_de     [NUM_AXES];
    logic [CNT_W-1:0]    cfg_tot    [NUM_AXES];

    assign cfg_se[AX_H]  = h_sync_end;
    assign cfg_ds[AX_H]  = h_disp_start;
    assign cfg_de[AX_H]  = h_disp_end;
    assign cfg_tot[AX_H] = h_total;
    assign cfg_se[AX_V]  = v_sync_end;
    assign cfg_ds[AX_V]  = v_disp_start;
    assign cfg_de[AX_V]  = v_disp_end;
    assign cfg_tot[AX_V] = v_total;

    // Pixels step every running cycle; lines step when a line wraps.
    assign adv[AX_H] = running;
    assign adv[AX_V] = running && last[AX_H];

    rtg_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_req       (en_req),
        .dis_req      (dis_req),
        .at_wrap      (last[AX_H] && last[AX_V]),
        .eof_irq_en   (eof_irq_en),
        .eof_clr      (eof_clr),
        .running      (running),
        .start        (start),
        .frame_end    (frame_end),
        .sts_disabled (sts_disabled),
        .sts_eof      (sts_eof),
        .irq          (irq)
    );

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        rtg_axis #(.W(CNT_W)) i_axis (
            .clk            (clk),
            .rst_n          (rst_n),
            .start          (start),
            .adv            (adv[a]),
            .reload         (frame_end),
            .cfg_sync_end   (cfg_se[a]),
            .cfg_disp_start (cfg_ds[a]),
            .cfg_disp_end   (cfg_de[a]),
            .cfg_total      (cfg_tot[a]),
            .last           (last[a]),
            .in_sync        (in_sync[a]),
            .in_disp        (in_disp[a]),
            .pos            (pos[a])
        );
    end

    rtg_out #(.W(CNT_W)) i_out (
        .running    (running),
        .h_sync     (in_sync[AX_H]),
        .v_sync     (in_sync[AX_V]),
        .h_disp     (in_disp[AX_H]),
        .v_disp     (in_disp[AX_V]),
        .h_pos      (pos[AX_H]),
        .v_pos      (pos[AX_V]),
        .hs_pol_low (hs_pol_low),
        .vs_pol_low (vs_pol_low),
        .de_pol_low (de_pol_low),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .px_x       (px_x),
        .px_y       (px_y)
    );

    assign eof_pulse = frame_end;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker (
    input logic clk,
    input logic rst_n,
    input logic running,
    input logic eof_pulse,
    input logic eof_clr,
    input logic sts_disabled,
    input logic sts_eof,
    input logic hsync,
    input logic hs_pol_low,
    input logic de,
    input logic de_pol_low
);

    assert_eof_sets_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> sts_eof);

    assert_clear_wins_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_clr && !eof_pulse) |=> !sts_eof);

    assert_idle_de_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (de == de_pol_low));

    assert_idle_hsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (hsync == hs_pol_low));

    assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_disabled) |-> $past(eof_pulse));

    assert_stopped_not_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_disabled |-> !running);

    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (!sts_disabled && !sts_eof));

endmodule

bind raster_timing_gen rtg_checker i_rtg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running),
    .eof_pulse    (eof_pulse),
    .eof_clr      (eof_clr),
    .sts_disabled (sts_disabled),
    .sts_eof      (sts_eof),
    .hsync        (hsync),
    .hs_pol_low   (hs_pol_low),
    .de           (de),
    .de_pol_low   (de_pol_low)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

    localparam int unsigned W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_req = 1'b0, dis_req = 1'b0;
    logic [W-1:0] h_sync_end = 12'd2, h_disp_start = 12'd4, h_disp_end = 12'd10, h_total = 12'd12;
    logic [W-1:0] v_sync_end = 12'd1, v_disp_start = 12'd2, v_disp_end = 12'd5, v_total = 12'd6;
    logic         hs_pol_low = 1'b0, vs_pol_low = 1'b0, de_pol_low = 1'b0;
    logic         eof_irq_en = 1'b0, eof_clr = 1'b0;
    logic         hsync, vsync, de, eof_pulse, sts_disabled, sts_eof, irq;
    logic [W-1:0] px_x, px_y;

    int n_tests = 0;
    int n_fail  = 0;
    int cur     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    raster_timing_gen #(.CNT_W(W)) i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .h_sync_end(h_sync_end), .h_disp_start(h_disp_start),
        .h_disp_end(h_disp_end), .h_total(h_total),
        .v_sync_end(v_sync_end), .v_disp_start(v_disp_start),
        .v_disp_end(v_disp_end), .v_total(v_total),
        .hs_pol_low(hs_pol_low), .vs_pol_low(vs_pol_low), .de_pol_low(de_pol_low),
        .eof_irq_en(eof_irq_en), .eof_clr(eof_clr),
        .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
        .eof_pulse(eof_pulse), .sts_disabled(sts_disabled), .sts_eof(sts_eof), .irq(irq)
    );

    // Offsets count cycles after the start request; 12x6 raster, active 6x3.
    typedef struct packed {
        logic [15:0]  off;
        logic         hs;
        logic         vs;
        logic         de;
        logic         eof;
        logic [W-1:0] x;
        logic [W-1:0] y;
    } vec_t;

    localparam int unsigned N_VEC = 12;
    localparam vec_t VECS [N_VEC] = '{
        '{16'd0,  1'b1, 1'b1, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd1,  1'b1, 1'b1, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd2,  1'b0, 1'b1, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd13, 1'b1, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd28, 1'b0, 1'b0, 1'b1, 1'b0, 12'd0, 12'd0},
        '{16'd33, 1'b0, 1'b0, 1'b1, 1'b0, 12'd5, 12'd0},
        '{16'd34, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd52, 1'b0, 1'b0, 1'b1, 1'b0, 12'd0, 12'd2},
        '{16'd57, 1'b0, 1'b0, 1'b1, 1'b0, 12'd5, 12'd2},
        '{16'd64, 1'b0, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0},
        '{16'd71, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0, 12'd0},
        '{16'd72, 1'b1, 1'b1, 1'b0, 1'b0, 12'd0, 12'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at offset %0d: actual=%0h expected=%0h", req, cur, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
        cur += k;
    endtask

    task automatic go_to(input int n);
        step(n - cur);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);

        // R5: state after reset
        chk("R5 stopped flag", 64'(sts_disabled), 64'd1);
        chk("R5 eof status", 64'(sts_eof), 64'd0);
        chk("R5 irq", 64'(irq), 64'd0);
        chk("R5 idle outputs", {hsync, vsync, de, eof_pulse}, 64'd0);

        // R4: idle levels follow polarity while stopped
        hs_pol_low = 1'b1; vs_pol_low = 1'b1; de_pol_low = 1'b1;
        #1;
        chk("R4 idle active-low", {hsync, vsync, de}, 64'b111);
        hs_pol_low = 1'b0; vs_pol_low = 1'b0; de_pol_low = 1'b0;

        // R6: start
        en_req = 1'b1; step(1); en_req = 1'b0; cur = 0;
        chk("R6 start clears stopped", 64'(sts_disabled), 64'd0);

        // R1 R2 R3: vector walk
        for (int i = 0; i < N_VEC; i++) begin
            go_to(int'(VECS[i].off));
            chk("R1/R2/R3 raster", {hsync, vsync, de, eof_pulse, px_x, px_y},
                {VECS[i].hs, VECS[i].vs, VECS[i].de, VECS[i].eof, VECS[i].x, VECS[i].y});
        end

        // R9: status, gating and clear
        chk("R9 eof status set", 64'(sts_eof), 64'd1);
        chk("R9 irq masked", 64'(irq), 64'd0);
        eof_irq_en = 1'b1;
        #1;
        chk("R9 irq enabled", 64'(irq), 64'd1);
        eof_clr = 1'b1; step(1); eof_clr = 1'b0;
        chk("R9 clear", {sts_eof, irq}, 64'd0);

        // R4: polarity while running, h4 v0
        hs_pol_low = 1'b1; vs_pol_low = 1'b1; de_pol_low = 1'b1;
        go_to(76);
        chk("R4 running active-low", {hsync, vsync, de}, 64'b101);
        hs_pol_low = 1'b0; vs_pol_low = 1'b0; de_pol_low = 1'b0;

        // R10: mid-frame total change applies from next frame
        h_total = 12'd16;
        go_to(143);
        chk("R10 old period kept", 64'(eof_pulse), 64'd1);
        go_to(215);
        chk("R10 no end at old period", 64'(eof_pulse), 64'd0);
        go_to(239);
        chk("R10 new period used", 64'(eof_pulse), 64'd1);

        // R7: stop waits for frame end
        go_to(250);
        dis_req = 1'b1; step(1); dis_req = 1'b0;
        chk("R7 still running after request", 64'(sts_disabled), 64'd0);
        go_to(335);
        chk("R7 frame completes", {eof_pulse, sts_disabled}, 64'b10);
        step(1);
        chk("R7 stopped after frame end", {sts_disabled, hsync, de}, 64'b100);
        chk("R9 last frame end recorded", 64'(sts_eof), 64'd1);

        // R6: restart clears status and begins at (0,0)
        en_req = 1'b1; step(1); en_req = 1'b0; cur = 0;
        chk("R6 restart clears status", {sts_disabled, sts_eof}, 64'b00);
        chk("R6 restart at origin", {hsync, vsync}, 64'b11);

        // R8: start during drain cancels without restart
        go_to(10);
        dis_req = 1'b1; step(1); dis_req = 1'b0;
        go_to(20);
        en_req = 1'b1; step(1); en_req = 1'b0;
        go_to(36);
        chk("R8 counters not restarted", {de, px_x, px_y}, {1'b1, 12'd0, 12'd0});
        go_to(95);
        chk("R8 frame end", 64'(eof_pulse), 64'd1);
        step(1);
        chk("R8 stop cancelled", {sts_disabled, hsync}, 64'b01);

        // R11: stop request in the end-of-frame cycle
        go_to(191);
        chk("R11 end-of-frame cycle", 64'(eof_pulse), 64'd1);
        dis_req = 1'b1; step(1); dis_req = 1'b0;
        chk("R11 stopped at boundary", {sts_disabled, de}, 64'b10);

        // R7: stop while stopped is ignored
        dis_req = 1'b1; step(1); dis_req = 1'b0;
        step(2);
        chk("R7 stop while stopped", {sts_disabled, hsync, vsync, de}, 64'b1000);

        done = 1'b1;
        report();
    end

endmodule